// File: doc/BRIEF.md
# Token-Passing Serial Readout Sequencer

This block sits in each front-end chip on a daisy chain whose members all drive the same two return lines to the acquisition system: one serial data line and one line that marks a transmission in progress. Only the chip holding the token may drive these lines. A chip takes the token on a rising edge of its start-of-readout input. It then drains its local word store onto the data line, one bit per readout clock, most significant bit first. When the store is empty it hands the token on with a one-cycle end-of-readout pulse. That pulse is wired straight into the start-of-readout input of the next chip.

The readout clock is slow (5 MHz), and a full readout has a few milliseconds between bunch trains to complete. Words are taken from local storage with a single-cycle pop handshake, and consecutive words follow each other with no idle bit between them. While the chip does not hold the token, both shared outputs are released: the output enable is low and the driven values are zero.

Top module: `tok_readout_ctrl`

## Requirements
- R1: During and after an active-low reset the controller is idle: `line_oe_o`, `line_data_o`, `line_busy_o`, `end_ro_o` and `rd_pop_o` are all 0. An assertion of reset during a readout releases the lines at once, and no readout or end pulse follows until a new start edge arrives.
- R2: A rising edge of `start_ro_i` while idle with `rd_avail_i` high pops the first word in that same cycle. The first bit of that word appears on the next cycle, with `line_oe_o` and `line_busy_o` high.
- R3: Each word goes out most significant bit first, one bit per clock, in storage order. The next word's first bit follows the previous word's last bit with no gap.
- R4: `line_busy_o` is high on every cycle from the first bit through the last bit of the whole readout. Whenever `line_oe_o` is 0, `line_busy_o` and `line_data_o` are 0.
- R5: `end_ro_o` is a single-cycle pulse in the cycle right after the last bit. The lines are already released in that cycle.
- R6: A start edge with no stored word (`rd_avail_i` low) gives the end pulse in the very next cycle, and the lines are never enabled.
- R7: `start_ro_i` is edge-sensitive. Holding it high for many cycles produces exactly one readout and one end pulse.
- R8: A start edge that arrives while bits are being shifted, or in the end-pulse cycle, is ignored. The bit stream is unchanged and no extra end pulse appears.
- R9: `rd_pop_o` is high for exactly one cycle per word: in the start cycle for the first word, and in the last-bit cycle of each word for the next one.
- R10: With one chip's `end_ro_o` connected to the next chip's `start_ro_i`, the two chips never enable their lines in the same cycle. The next chip's first bit appears two cycles after the previous chip's last bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Readout clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_ro_i | input | 1 | Token in; a rising edge starts the readout |
| end_ro_o | output | 1 | Token out; one-cycle pulse when the readout is finished |
| rd_avail_i | input | 1 | Local storage holds at least one word |
| rd_word_i | input | WORD_W | Word at the head of local storage |
| rd_pop_o | output | 1 | Takes the head word this cycle |
| line_data_o | output | 1 | Serial data toward the shared data line |
| line_busy_o | output | 1 | Transmission-active flag toward the shared line |
| line_oe_o | output | 1 | Drive enable for both shared lines |

## Verification
The main function is tried with a single word, with several words back to back, with an empty store, and with a two-chip chain. The single word pins down the bit order and the start latency. The multi-word run shows whether the reload between words leaves a bubble or repeats a bit. The empty store separates the immediate token pass from the normal path. The chain run shows that the handover leaves exactly one idle cycle and never lets two drivers overlap. Further runs hold start high, pulse it during shifting and during the end cycle, and pull reset in mid-word, so that an edge detector or a state decode that is wrong gives extra end pulses or a changed stream.

// File: rtl/tok_ro_pkg.sv
package tok_ro_pkg;

    typedef enum logic [1:0] {
        RO_IDLE  = 2'd0,
        RO_SHIFT = 2'd1,
        RO_PASS  = 2'd2
    } ro_state_e;

    typedef struct packed {
        ro_state_e state;
    } ro_fsm_t;

    typedef struct packed {
        logic load;
        logic shift;
        logic pop;
    } ro_ctl_t;

endpackage

// File: rtl/tok_ro_edge.sv
module tok_ro_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lvl_i,
    output logic rise_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
        rise_o = lvl_i & ~prev_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= prev_d;
    end
endmodule

// File: rtl/tok_ro_shreg.sv
module tok_ro_shreg #(
    parameter int WORD_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              msb_o
);
    logic [WORD_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_i)       sh_d = word_i;
        else if (shift_i) sh_d = {sh_q[WORD_W-2:0], 1'b0};
        msb_o = sh_q[WORD_W-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= sh_d;
    end
endmodule

// File: rtl/tok_ro_bitcnt.sv
module tok_ro_bitcnt #(
    parameter int WORD_W = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    input  logic dec_i,
    output logic last_o
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)     cnt_d = TOP;
        else if (dec_i) cnt_d = cnt_q - 1'b1;
        last_o = (cnt_q == '0);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end
endmodule

// File: rtl/tok_readout_ctrl.sv
module tok_readout_ctrl
    import tok_ro_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_ro_i,
    output logic              end_ro_o,
    input  logic              rd_avail_i,
    input  logic [WORD_W-1:0] rd_word_i,
    output logic              rd_pop_o,
    output logic              line_data_o,
    output logic              line_busy_o,
    output logic              line_oe_o
);
    ro_fsm_t fsm_d, fsm_q;
    ro_ctl_t ctl;
    logic    start_rise;
    logic    sh_msb;
    logic    word_last;

    tok_ro_edge u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (start_ro_i),
        .rise_o (start_rise)
    );

    tok_ro_shreg #(.WORD_W(WORD_W)) u_shreg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (ctl.load),
        .shift_i (ctl.shift),
        .word_i  (rd_word_i),
        .msb_o   (sh_msb)
    );

    tok_ro_bitcnt #(.WORD_W(WORD_W)) u_bitcnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (ctl.load),
        .dec_i  (ctl.shift),
        .last_o (word_last)
    );

    always_comb begin
        fsm_d = fsm_q;
        ctl   = '0;
        unique case (fsm_q.state)
            RO_IDLE: begin
                if (start_rise) begin
                    if (rd_avail_i) begin
                        ctl.pop     = 1'b1;
                        ctl.load    = 1'b1;
                        fsm_d.state = RO_SHIFT;
                    end else begin
                        fsm_d.state = RO_PASS;
                    end
                end
            end
            RO_SHIFT: begin
                ctl.shift = 1'b1;
                if (word_last) begin
                    if (rd_avail_i) begin
                        ctl.pop  = 1'b1;
                        ctl.load = 1'b1;
                    end else begin
                        fsm_d.state = RO_PASS;
                    end
                end
            end
            RO_PASS: fsm_d.state = RO_IDLE;
            default: fsm_d.state = RO_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fsm_q <= '{state: RO_IDLE};
        else         fsm_q <= fsm_d;
    end

    always_comb begin
        line_oe_o   = (fsm_q.state == RO_SHIFT);
        line_busy_o = line_oe_o;
        line_data_o = line_oe_o & sh_msb;
        end_ro_o    = (fsm_q.state == RO_PASS);
        rd_pop_o    = ctl.pop;
    end
endmodule

// File: rtl/tok_readout_ctrl_chk.sv
module tok_readout_ctrl_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_ro_i,
    input logic              end_ro_o,
    input logic              rd_avail_i,
    input logic [WORD_W-1:0] rd_word_i,
    input logic              rd_pop_o,
    input logic              line_data_o,
    input logic              line_busy_o,
    input logic              line_oe_o
);
    localparam int PH_W = $clog2(WORD_W);
    localparam logic [PH_W-1:0] PH_TOP = PH_W'(WORD_W - 1);

    logic [PH_W-1:0] ph_q;
    logic            unused_ok;

    assign unused_ok = start_ro_i ^ (^rd_word_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              ph_q <= '0;
        else if (!line_oe_o)      ph_q <= '0;
        else if (ph_q == PH_TOP)  ph_q <= '0;
        else                      ph_q <= ph_q + 1'b1;
    end

    assert_released_when_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !line_oe_o |-> (!line_data_o && !line_busy_o));

    assert_first_bit_after_pop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(line_busy_o) |-> $past(rd_pop_o));

    assert_reload_on_boundary_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_pop_o && line_oe_o) |-> (ph_q == PH_TOP));

    assert_no_gap_between_words_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (line_oe_o && ph_q != PH_TOP) |=> line_busy_o);

    assert_end_after_last_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (line_oe_o && ph_q == PH_TOP && !rd_avail_i) |=> (end_ro_o && !line_oe_o));

    assert_end_single_cycle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        end_ro_o |=> !end_ro_o);

    assert_pop_begins_word_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_pop_o |=> line_oe_o);

    assert_pass_without_drive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        end_ro_o |-> !line_oe_o);
endmodule

bind tok_readout_ctrl tok_readout_ctrl_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/tok_readout_ctrl_test.sv
`timescale 1ns/1ps
module tok_readout_ctrl_test;
    localparam int CLK_PERIOD = 200;
    localparam int W   = 16;
    localparam int LOG = 160;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic         rst_n;
    logic         start_ro;
    logic         end_ro, pop, dat, busy, oe;
    logic [W-1:0] mem [8];
    int           rd_idx, wr_cnt;
    logic         avail;
    logic [W-1:0] head;

    logic         nx_end, nx_pop, nx_dat, nx_busy, nx_oe;
    int           nx_left;
    logic [W-1:0] nx_word;

    assign avail = (rd_idx < wr_cnt);
    assign head  = avail ? mem[rd_idx[2:0]] : '0;

    tok_readout_ctrl #(.WORD_W(W)) uut (
        .clk_i(clk), .rst_ni(rst_n), .start_ro_i(start_ro), .end_ro_o(end_ro),
        .rd_avail_i(avail), .rd_word_i(head), .rd_pop_o(pop),
        .line_data_o(dat), .line_busy_o(busy), .line_oe_o(oe)
    );

    tok_readout_ctrl #(.WORD_W(W)) u_next (
        .clk_i(clk), .rst_ni(rst_n), .start_ro_i(end_ro), .end_ro_o(nx_end),
        .rd_avail_i(nx_left > 0), .rd_word_i(nx_word), .rd_pop_o(nx_pop),
        .line_data_o(nx_dat), .line_busy_o(nx_busy), .line_oe_o(nx_oe)
    );

    int n_chk = 0, n_fail = 0, cyc = 0, overlap = 0;
    logic oe_l[LOG], dat_l[LOG], busy_l[LOG], end_l[LOG], pop_l[LOG];
    logic nx_oe_l[LOG], nx_dat_l[LOG], nx_end_l[LOG];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        logic s_pop, s_nx;
        #(CLK_PERIOD/4);
        if (cyc < LOG) begin
            oe_l[cyc] = oe; dat_l[cyc] = dat; busy_l[cyc] = busy;
            end_l[cyc] = end_ro; pop_l[cyc] = pop;
            nx_oe_l[cyc] = nx_oe; nx_dat_l[cyc] = nx_dat; nx_end_l[cyc] = nx_end;
        end
        if (oe && nx_oe) overlap++;
        s_pop = pop; s_nx = nx_pop;
        @(negedge clk);
        if (s_pop) rd_idx++;
        if (s_nx)  nx_left--;
        cyc++;
    endtask

    task automatic fresh(input int n);
        rd_idx = 0; wr_cnt = n; cyc = 0; overlap = 0;
    endtask

    // Stream started with start high in cycle 0: pops at k*W, bits in 1..n*W, end at n*W+1.
    task automatic verify(input int n, input string tag);
        int bad_oe = 0, bad_dat = 0, bad_busy = 0, bad_end = 0, bad_pop = 0;
        int ends = 0, pops = 0;
        for (int c = 0; c < n*W + 6; c++) begin
            bit e_oe = (c >= 1) && (c <= n*W);
            bit e_dat = 1'b0;
            bit e_pop = (n > 0) && (c % W == 0) && (c / W < n);
            if (e_oe) e_dat = mem[(c-1)/W][W-1-((c-1)%W)];
            if (oe_l[c] !== e_oe) bad_oe++;
            if (dat_l[c] !== e_dat) bad_dat++;
            if (busy_l[c] !== e_oe) bad_busy++;
            if (end_l[c] !== (c == n*W+1)) bad_end++;
            if (pop_l[c] !== e_pop) bad_pop++;
            if (end_l[c] === 1'b1) ends++;
            if (pop_l[c] === 1'b1) pops++;
        end
        check(bad_oe == 0,   "R2", {tag, " enable window mismatches"}, bad_oe, 0);
        check(bad_dat == 0,  "R3", {tag, " data bit mismatches"}, bad_dat, 0);
        check(bad_busy == 0, "R4", {tag, " busy flag mismatches"}, bad_busy, 0);
        check(bad_end == 0,  "R5", {tag, " end pulse placement"}, bad_end, 0);
        check(ends == 1,     "R5", {tag, " end pulse count"}, ends, 1);
        check(bad_pop == 0 && pops == n, "R9", {tag, " pop count"}, pops, n);
    endtask

    task automatic t_reset();
        int bad = 0;
        fresh(0);
        for (int i = 0; i < 4; i++) begin
            tick();
            if (oe_l[i] || dat_l[i] || busy_l[i] || end_l[i] || pop_l[i]) bad++;
        end
        check(bad == 0, "R1", "outputs idle after reset", bad, 0);
    endtask

    task automatic t_single();
        mem[0] = 16'hA5C3; fresh(1);
        start_ro = 1'b1; tick(); start_ro = 1'b0;
        for (int i = 0; i < W + 6; i++) tick();
        verify(1, "single word");
    endtask

    task automatic t_multi();
        mem[0] = 16'h8001; mem[1] = 16'h7FFE; mem[2] = 16'h3C5A; fresh(3);
        start_ro = 1'b1; tick(); start_ro = 1'b0;
        for (int i = 0; i < 3*W + 6; i++) tick();
        verify(3, "three words");
    endtask

    task automatic t_empty();
        int en = 0, ends = 0;
        fresh(0);
        start_ro = 1'b1; tick(); start_ro = 1'b0;
        for (int i = 0; i < 6; i++) tick();
        for (int c = 0; c < 7; c++) begin
            if (oe_l[c]) en++;
            if (end_l[c]) ends++;
        end
        check(end_l[1] === 1'b1, "R6", "end pulse one cycle after start", end_l[1], 1);
        check(ends == 1 && en == 0, "R6", "empty store: pulses and enabled cycles",
              ends * 100 + en, 100);
    endtask

    task automatic t_held();
        int ends = 0;
        mem[0] = 16'h0F0F; fresh(1);
        start_ro = 1'b1;
        for (int i = 0; i < 3*W; i++) tick();
        start_ro = 1'b0;
        for (int i = 0; i < 4; i++) tick();
        for (int c = 0; c < 3*W + 4; c++) if (end_l[c]) ends++;
        check(ends == 1, "R7", "held start gives one end pulse", ends, 1);
        verify(1, "held start");
    endtask

    task automatic t_mid_start();
        int ends = 0;
        mem[0] = 16'hC0DE; mem[1] = 16'h1357; fresh(2);
        for (int c = 0; c < 2*W + 8; c++) begin
            start_ro = (c == 0) || (c == 5) || (c == W) || (c == 2*W + 1);
            tick();
        end
        start_ro = 1'b0;
        for (int c = 0; c < 2*W + 8; c++) if (end_l[c]) ends++;
        check(ends == 1, "R8", "start edges during readout ignored", ends, 1);
        verify(2, "R8 restart pulses");
    endtask

    task automatic t_chain();
        int bad = 0;
        mem[0] = 16'hBEEF; fresh(1);
        nx_word = 16'h1234; nx_left = 1;
        start_ro = 1'b1; tick(); start_ro = 1'b0;
        for (int i = 0; i < 2*W + 8; i++) tick();
        for (int c = 0; c < 2*W + 8; c++) begin
            bit e_oe = (c >= W + 2) && (c <= 2*W + 1);
            bit e_dat = e_oe ? nx_word[W-1-(c-W-2)] : 1'b0;
            if (nx_oe_l[c] !== e_oe || nx_dat_l[c] !== e_dat) bad++;
        end
        check(bad == 0, "R10", "next chip stream after handover", bad, 0);
        check(nx_end_l[2*W+2] === 1'b1, "R10", "next chip end pulse", nx_end_l[2*W+2], 1);
        check(overlap == 0, "R10", "cycles with two drivers", overlap, 0);
        nx_left = 0;
    endtask

    task automatic t_reset_mid();
        int bad = 0;
        mem[0] = 16'hFFFF; mem[1] = 16'hFFFF; fresh(2);
        start_ro = 1'b1; tick(); start_ro = 1'b0;
        for (int i = 0; i < 5; i++) tick();
        rst_n = 1'b0;
        #(CLK_PERIOD/4);
        check(!oe && !busy && !dat && !end_ro, "R1", "lines released by reset mid-word",
              {oe, busy, dat, end_ro}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        cyc = 0;
        for (int i = 0; i < 3*W; i++) begin
            tick();
            if (oe_l[i] || end_l[i] || pop_l[i]) bad++;
        end
        check(bad == 0, "R1", "stays idle after reset until new start", bad, 0);
    endtask

    initial begin
        rst_n = 1'b0; start_ro = 1'b0; nx_left = 0; nx_word = '0;
        rd_idx = 0; wr_cnt = 0;
        for (int i = 0; i < 8; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        #(CLK_PERIOD/4);
        check(!oe && !busy && !dat && !end_ro && !pop, "R1", "outputs during reset",
              {oe, busy, dat, end_ro, pop}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_multi();
        t_empty();
        t_held();
        t_mid_start();
        t_chain();
        t_reset_mid();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule